// File: doc/BRIEF.md
# Programmable Sample Clock Generator

This block supplies the sample-rate strobe for a voice storage controller. The strobe can come from either of two sources. When an external reference clock is toggling, the block counts its rising edges through a programmable prescaler of ratio N and then a fixed post-divider (128 by default), so one strobe marks N × 128 reference edges. When the reference is quiet, the block derives the strobe from the system clock at one of four preset rates.

Configuration arrives as a 10-bit word with a load strobe, as part of the controller's power-up command. The upper eight bits hold the prescaler field and the low two bits pick the internal rate. An accepted load restarts both divider chains, so the new rate starts from a clean phase. A load that asks for the forbidden ratio 2 is dropped. Source selection is automatic. The reference is synchronised into the system domain and its rising edges are detected there. A watchdog then marks the reference as present on any edge, and marks it absent after a fixed run of system cycles with no edge. The block reports which source is in use.

Top module: `sample_clock_gen`

## Requirements
- R1: After reset the internal source is active (`ext_active` = 0), the rate code is 00 and the prescaler field is 1. The first strobe comes SYS_CLK_HZ/6400 cycles after the last reset cycle.
- R2: With the internal source active, the strobe period in system cycles is SYS_CLK_HZ divided by the selected rate. The rate code sits in `cfg_param[1:0]`: 00 selects 6400 Hz, 01 selects 4000 Hz, 10 selects 8000 Hz and 11 selects 5300 Hz.
- R3: With the external source active, one strobe is produced every N × FIX_DIV rising reference edges (FIX_DIV defaults to 128). N is taken from `cfg_param[9:2]`, and a field of 0 means N = 256.
- R4: A load whose `cfg_param[9:2]` equals 2 is ignored. Both the stored setting and the current divider phase stay as they were.
- R5: A rising edge on `ext_clk` sets `ext_active`. That edge counts as the first edge of the external divider.
- R6: `ext_active` clears after TIMEOUT system cycles (1024 by default) with no detected rising edge. Until then it stays set.
- R7: `sample_tick` is high for exactly one system cycle at a time.
- R8: An accepted load clears the divider chains. With the internal source, the first strobe after the load comes exactly one new period after the load cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_clk | input | 1 | External reference clock, asynchronous |
| cfg_load | input | 1 | Configuration load strobe |
| cfg_param | input | 10 | Prescaler field [9:2], internal rate code [1:0] |
| sample_tick | output | 1 | One-cycle sample-rate strobe |
| ext_active | output | 1 | High while the external source drives the strobe |

## Verification
The bench goes after four corner cases:

- **Prescaler extremes.** Field 0 must give ratio 256 and field 255 must give ratio 255. A design that treated 0 as 0 or 1 would give a very short period or hang.
- **Forbidden ratio 2.** A load with ratio 2 is tried in both source modes. A design that accepted it, or that restarted the counters on it, would shift the next strobe.
- **Watchdog edges.** `ext_active` is sampled just before and just after the timeout. An off-by-window watchdog would fall early or never fall.
- **Strobe phase.** The exact phase of the first strobe is checked after reset and after a load. A divider that was not cleared, or one that was off by one, would place that strobe a cycle or a period away.

// File: rtl/sample_clock_gen_pkg.sv
`timescale 1ns/1ps
package sample_clock_gen_pkg;

    typedef enum logic [1:0] {
        RATE_6K4 = 2'b00,
        RATE_4K0 = 2'b01,
        RATE_8K0 = 2'b10,
        RATE_5K3 = 2'b11
    } rate_sel_e;

    typedef struct packed {
        logic [7:0] ratio;
        rate_sel_e  rate;
    } clk_cfg_t;

    localparam logic [7:0] RATIO_FORBIDDEN = 8'd2;
    localparam clk_cfg_t   CFG_RESET       = '{ratio: 8'd1, rate: RATE_6K4};

    function automatic int unsigned rate_hz(input rate_sel_e r);
        case (r)
            RATE_6K4: return 6400;
            RATE_4K0: return 4000;
            RATE_8K0: return 8000;
            default:  return 5300;
        endcase
    endfunction

    // field 0 stands for the largest ratio
    function automatic logic [8:0] ratio_of(input logic [7:0] field);
        return (field == 8'd0) ? 9'd256 : {1'b0, field};
    endfunction

endpackage

// File: rtl/sample_clock_gen_cfg.sv
`timescale 1ns/1ps
module sample_clock_gen_cfg
    import sample_clock_gen_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  logic [9:0] param,
    output clk_cfg_t   cfg,
    output logic       accepted
);
    assign accepted = load && (param[9:2] != RATIO_FORBIDDEN);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= CFG_RESET;
        end else if (accepted) begin
            cfg.ratio <= param[9:2];
            cfg.rate  <= rate_sel_e'(param[1:0]);
        end
    end
endmodule

// File: rtl/sample_clock_gen_detect.sv
`timescale 1ns/1ps
module sample_clock_gen_detect #(
    parameter int unsigned TIMEOUT = 1024,
    localparam int W = $clog2(TIMEOUT + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic ext_clk,
    output logic rise,
    output logic active
);
    logic [2:0]   sync_q;
    logic [W-1:0] quiet_q;

    assign rise = sync_q[1] && !sync_q[2];

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q  <= '0;
            quiet_q <= '0;
            active  <= 1'b0;
        end else begin
            sync_q <= {sync_q[1:0], ext_clk};
            if (rise) begin
                quiet_q <= '0;
                active  <= 1'b1;
            end else if (quiet_q == W'(TIMEOUT - 1)) begin
                active  <= 1'b0;
            end else begin
                quiet_q <= quiet_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/sample_clock_gen_intdiv.sv
`timescale 1ns/1ps
module sample_clock_gen_intdiv
    import sample_clock_gen_pkg::*;
#(
    parameter int unsigned SYS_CLK_HZ = 20_000_000,
    localparam int unsigned MAX_DIV = SYS_CLK_HZ / 4000,
    localparam int W = $clog2(MAX_DIV + 1)
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      clear,
    input  rate_sel_e rate,
    output logic      tick
);
    localparam int unsigned DIV_6K4 = SYS_CLK_HZ / rate_hz(RATE_6K4);
    localparam int unsigned DIV_4K0 = SYS_CLK_HZ / rate_hz(RATE_4K0);
    localparam int unsigned DIV_8K0 = SYS_CLK_HZ / rate_hz(RATE_8K0);
    localparam int unsigned DIV_5K3 = SYS_CLK_HZ / rate_hz(RATE_5K3);

    logic [W-1:0] cnt_q;
    logic [W-1:0] last;

    always_comb begin
        case (rate)
            RATE_6K4: last = W'(DIV_6K4 - 1);
            RATE_4K0: last = W'(DIV_4K0 - 1);
            RATE_8K0: last = W'(DIV_8K0 - 1);
            default:  last = W'(DIV_5K3 - 1);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt_q <= '0;
            tick  <= 1'b0;
        end else if (cnt_q == last) begin
            cnt_q <= '0;
            tick  <= 1'b1;
        end else begin
            cnt_q <= cnt_q + 1'b1;
            tick  <= 1'b0;
        end
    end
endmodule

// File: rtl/sample_clock_gen_extdiv.sv
`timescale 1ns/1ps
module sample_clock_gen_extdiv
    import sample_clock_gen_pkg::*;
#(
    parameter int unsigned FIX_DIV = 128,
    localparam int PW = $clog2(FIX_DIV)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       clear,
    input  logic       enable,
    input  logic       rise,
    input  logic [7:0] ratio_field,
    output logic       tick
);
    logic [8:0]    pre_q;
    logic [PW-1:0] post_q;
    logic [8:0]    pre_last;

    assign pre_last = ratio_of(ratio_field) - 9'd1;

    always_ff @(posedge clk) begin
        if (rst || clear || !enable) begin
            pre_q  <= '0;
            post_q <= '0;
            tick   <= 1'b0;
        end else begin
            tick <= 1'b0;
            if (rise) begin
                if (pre_q == pre_last) begin
                    pre_q <= '0;
                    if (post_q == PW'(FIX_DIV - 1)) begin
                        post_q <= '0;
                        tick   <= 1'b1;
                    end else begin
                        post_q <= post_q + 1'b1;
                    end
                end else begin
                    pre_q <= pre_q + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/sample_clock_gen.sv
`timescale 1ns/1ps
module sample_clock_gen
    import sample_clock_gen_pkg::*;
#(
    parameter int unsigned SYS_CLK_HZ = 20_000_000,
    parameter int unsigned FIX_DIV    = 128,
    parameter int unsigned TIMEOUT    = 1024
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ext_clk,
    input  logic       cfg_load,
    input  logic [9:0] cfg_param,
    output logic       sample_tick,
    output logic       ext_active
);
    clk_cfg_t cfg_q;
    logic     load_ok;
    logic     ext_rise;
    logic     int_tick;
    logic     ext_tick;

    sample_clock_gen_cfg u_cfg (
        .clk      (clk),
        .rst      (rst),
        .load     (cfg_load),
        .param    (cfg_param),
        .cfg      (cfg_q),
        .accepted (load_ok)
    );

    sample_clock_gen_detect #(.TIMEOUT(TIMEOUT)) u_detect (
        .clk     (clk),
        .rst     (rst),
        .ext_clk (ext_clk),
        .rise    (ext_rise),
        .active  (ext_active)
    );

    sample_clock_gen_intdiv #(.SYS_CLK_HZ(SYS_CLK_HZ)) u_intdiv (
        .clk   (clk),
        .rst   (rst),
        .clear (load_ok || ext_active),
        .rate  (cfg_q.rate),
        .tick  (int_tick)
    );

    sample_clock_gen_extdiv #(.FIX_DIV(FIX_DIV)) u_extdiv (
        .clk         (clk),
        .rst         (rst),
        .clear       (load_ok),
        .enable      (ext_active || ext_rise),
        .rise        (ext_rise),
        .ratio_field (cfg_q.ratio),
        .tick        (ext_tick)
    );

    assign sample_tick = ext_active ? ext_tick : int_tick;
endmodule

// File: rtl/sample_clock_gen_checker.sv
`timescale 1ns/1ps
module sample_clock_gen_checker #(
    parameter int unsigned TIMEOUT = 1024,
    localparam int W = $clog2(TIMEOUT + 1)
) (
    input logic       clk,
    input logic       rst,
    input logic       ext_clk,
    input logic       cfg_load,
    input logic [9:0] cfg_param,
    input logic       sample_tick,
    input logic       ext_active,
    input logic [7:0] cfg_ratio,
    input logic [1:0] cfg_rate
);
    logic         ext_prev;
    logic [W-1:0] since_rise;

    always_ff @(posedge clk) begin
        if (rst) begin
            ext_prev   <= 1'b0;
            since_rise <= '0;
        end else begin
            ext_prev <= ext_clk;
            if (ext_clk && !ext_prev)
                since_rise <= '0;
            else if (since_rise != W'(TIMEOUT))
                since_rise <= since_rise + 1'b1;
        end
    end

    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (!ext_active && !sample_tick));

    a_r7_single_tick: assert property (@(posedge clk) disable iff (rst)
        sample_tick |=> !sample_tick);

    a_r6_no_early_fallback: assert property (@(posedge clk) disable iff (rst)
        $fell(ext_active) |-> (since_rise == W'(TIMEOUT)));

    a_r4_ratio2_ignored: assert property (@(posedge clk) disable iff (rst)
        (cfg_load && cfg_param[9:2] == 8'd2) |=> ($stable(cfg_ratio) && $stable(cfg_rate)));

    a_r2_load_taken: assert property (@(posedge clk) disable iff (rst)
        (cfg_load && cfg_param[9:2] != 8'd2)
            |=> (cfg_rate == $past(cfg_param[1:0]) && cfg_ratio == $past(cfg_param[9:2])));
endmodule

bind sample_clock_gen sample_clock_gen_checker #(.TIMEOUT(TIMEOUT)) u_checker (
    .clk         (clk),
    .rst         (rst),
    .ext_clk     (ext_clk),
    .cfg_load    (cfg_load),
    .cfg_param   (cfg_param),
    .sample_tick (sample_tick),
    .ext_active  (ext_active),
    .cfg_ratio   (cfg_q.ratio),
    .cfg_rate    (cfg_q.rate)
);

// File: tb/sample_clock_gen_bench.sv
`timescale 1ns/1ps
module sample_clock_gen_bench;
    localparam int unsigned SYS_HZ  = 64000;   // internal periods 10/16/8/12
    localparam int unsigned FIXD    = 16;
    localparam int unsigned TOUT    = 1024;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ext_clk = 1'b0;
    logic       cfg_load = 1'b0;
    logic [9:0] cfg_param = '0;
    logic       sample_tick;
    logic       ext_active;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int ext_half = 0;   // half period of ext_clk in system cycles, 0 = stopped

    sample_clock_gen #(.SYS_CLK_HZ(SYS_HZ), .FIX_DIV(FIXD), .TIMEOUT(TOUT)) u_sample_clock_gen (
        .clk(clk), .rst(rst), .ext_clk(ext_clk), .cfg_load(cfg_load),
        .cfg_param(cfg_param), .sample_tick(sample_tick), .ext_active(ext_active)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    always begin
        if (ext_half == 0) #4;
        else begin
            #(ext_half * 4);
            ext_clk = ~ext_clk;
        end
    end

    // {param, ext half period, expected period, expected ext_active}
    typedef struct packed {
        logic [9:0] param;
        int         half;
        int         period;
        logic       act;
    } vec_t;
    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{10'b00000001_00, 0, 10,   1'b0},   // R2 6.4k
        '{10'b00000001_01, 0, 16,   1'b0},   // R2 4.0k
        '{10'b00000001_10, 0, 8,    1'b0},   // R2 8.0k
        '{10'b00000001_11, 0, 12,   1'b0},   // R2 5.3k
        '{10'b00000001_00, 1, 32,   1'b1},   // R3 N=1
        '{10'b00000011_10, 2, 192,  1'b1},   // R3 N=3
        '{10'b00000000_00, 1, 8192, 1'b1},   // R3 field 0 -> 256
        '{10'b11111111_01, 1, 8160, 1'b1}    // R3 N=255
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_tick(output int at);
        int n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!sample_tick && n < 20000);
        at = sample_tick ? cyc : -1;
    endtask

    task automatic wait_active(input logic v);
        int n = 0;
        while (ext_active !== v && n < 3000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic load(input logic [9:0] p, output int at);
        @(negedge clk);
        cfg_param = p;
        cfg_load  = 1'b1;
        @(negedge clk);
        at = cyc;
        cfg_load = 1'b0;
    endtask

    initial begin
        int t0, t1, t2, tl;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t0 = cyc;
        check("R1 ext_active after reset", int'(ext_active), 0);
        check("R1 no tick after reset", int'(sample_tick), 0);
        wait_tick(t1);
        check("R1 first tick phase", t1 - t0, 10);

        for (int i = 0; i < NV; i++) begin
            load(VECS[i].param, tl);
            ext_half = VECS[i].half;
            wait_active(VECS[i].act);
            check("R5/R6 source select", int'(ext_active), int'(VECS[i].act));
            wait_tick(t1);
            wait_tick(t2);
            check(VECS[i].act ? "R3 ext period" : "R2 int period", t2 - t1, VECS[i].period);
        end

        // R4 in external mode: N=1 kept when ratio 2 requested
        load(10'b00000001_00, tl);
        wait_tick(t1);
        load(10'b00000010_00, tl);
        wait_tick(t2);
        check("R4 ext ratio2 ignored", t2 - t1, 32);

        // R6 fallback window
        @(negedge clk);
        ext_half = 0;
        t0 = cyc;
        repeat (1000) @(negedge clk);
        check("R6 still active before timeout", int'(ext_active), 1);
        repeat (40) @(negedge clk);
        check("R6 fallback after timeout", int'(ext_active), 0);
        check("R6 elapsed", (cyc - t0 >= 1040) ? 1 : 0, 1);

        // R4 internal mode: rate 01 kept, phase undisturbed
        load(10'b00000001_01, tl);
        wait_tick(t1);
        load(10'b00000010_10, tl);
        wait_tick(t2);
        check("R4 int ratio2 ignored", t2 - t1, 16);

        // R8 restart on accepted load
        wait_tick(t1);
        repeat (5) @(negedge clk);
        load(10'b00000001_10, tl);
        wait_tick(t2);
        check("R8 first tick after load", t2 - tl, 8);

        // R7 width of the strobe
        wait_tick(t1);
        @(negedge clk);
        check("R7 single-cycle tick", int'(sample_tick), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(190000 * 4);
        fails++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule